// File: doc/BRIEF.md
# Banked Register Address Pointer

This block holds the internal register pointer of a two-port expander with 22 registers, arranged as 11 register pairs. Each pair has one register for port A and one for port B. A serial front-end loads the pointer with the address byte it receives. It then pulses an advance strobe once for every data byte transferred. The block turns the current pointer value into a physical register index, a port flag, a valid flag and a configuration-register select. These outputs feed the register file.

Two configuration inputs control the block. The first chooses the address map. The interleaved map puts the two members of each pair at neighbouring addresses. The banked map gives port A and port B separate address windows. The second input chooses how the pointer moves after each byte:

- In sequential mode it counts up and wraps to 00h after the last register.
- In byte mode with the banked map it stays where it is.
- In byte mode with the interleaved map it flips between the two members of its pair.

The hold-mode input selects sequential mode when it is low. A cleared configuration register therefore gives sequential stepping. The physical index numbers the registers as twice the pair number plus the port bit.

Top module: `regptr_unit`

## Requirements
- R1: A synchronous reset sets the pointer to 00h. Reset takes priority over a load or an advance in the same cycle.
- R2: A load with `ptr_load` high appears on `ptr_addr` one clock edge later. When `ptr_load` and `ptr_adv` are high in the same cycle, the loaded address wins.
- R3: Interleaved map (`map_banked` = 0): addresses 00h..15h are valid, `reg_index` equals the address, and `reg_port_b` equals address bit 0. Addresses 16h..1Fh are invalid.
- R4: Banked map (`map_banked` = 1): addresses 00h..0Ah select port A with index 2*addr. Addresses 10h..1Ah select port B with index 2*(addr-10h)+1. Any other address is invalid. Whenever an address is invalid, `reg_valid`, `reg_index`, `reg_port_b` and `cfg_sel` are all 0.
- R5: `cfg_sel` is 1 exactly at pair 5: at 0Ah and 0Bh in the interleaved map, and at 05h and 15h in the banked map.
- R6: Sequential stepping in the interleaved map adds one per advance. From 15h, or from any higher address, it goes to 00h.
- R7: Sequential stepping in the banked map adds one per advance and also passes through the unpopulated addresses 0Bh..0Fh. From 1Ah, or from any higher address, it goes to 00h.
- R8: In byte mode (`hold_mode` = 1) with the interleaved map, each advance inverts pointer bit 0. The pointer therefore alternates between the two members of a pair, starting from whichever one was loaded.
- R9: In byte mode with the banked map, an advance leaves the pointer unchanged.
- R10: With no load and no advance, the pointer keeps its value. A change of `map_banked` re-translates that pointer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ptr_load | input | 1 | Load the pointer from `ptr_load_addr` |
| ptr_load_addr | input | 5 | Register address received from the front-end |
| ptr_adv | input | 1 | One pulse per data byte transferred |
| map_banked | input | 1 | 1 = separate port banks, 0 = interleaved pairs |
| hold_mode | input | 1 | 1 = byte mode, 0 = sequential mode |
| ptr_addr | output | 5 | Current logical register address |
| reg_valid | output | 1 | Address maps to a populated register |
| reg_index | output | 5 | Physical register index, 2*pair + port |
| reg_port_b | output | 1 | Selected register belongs to port B |
| cfg_sel | output | 1 | Selected register is the shared configuration register |

## Verification
A load or an advance changes `ptr_addr` at the first rising edge that samples it. The translated outputs follow the pointer and `map_banked` combinationally, so they are due in that same cycle. The bench drives every input on the falling edge and compares all five outputs on the next falling edge, one full rising edge later. Mid-step samples of the translated outputs therefore never occur. A change of `map_banked` with no pointer activity is checked at that same next falling edge, so the re-translation is seen without any pointer change.

// File: rtl/regptr_pkg.sv
package regptr_pkg;

    localparam int unsigned PAIRS_DEF    = 11;
    localparam int unsigned ADDR_W_DEF   = 5;
    localparam int unsigned BANK_B_DEF   = 16;
    localparam int unsigned CFG_PAIR_DEF = 5;

    typedef enum logic [1:0] {
        STEP_INC    = 2'd0,
        STEP_TOGGLE = 2'd1,
        STEP_HOLD   = 2'd2
    } step_e;

    typedef struct packed {
        logic valid;
        logic port_b;
        logic cfg;
    } map_flags_t;

    function automatic step_e step_kind(input logic banked, input logic hold);
        if (!hold)
            return STEP_INC;
        else if (banked)
            return STEP_HOLD;
        else
            return STEP_TOGGLE;
    endfunction

endpackage

// File: rtl/regptr_step.sv
module regptr_step
    import regptr_pkg::*;
#(
    parameter int unsigned AW          = ADDR_W_DEF,
    parameter int unsigned NUM_PAIRS   = PAIRS_DEF,
    parameter int unsigned BANK_B_BASE = BANK_B_DEF
) (
    input  logic [AW-1:0] cur,
    input  logic          banked,
    input  logic          hold,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          adv,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] LAST_IL = AW'(2 * NUM_PAIRS - 1);
    localparam logic [AW-1:0] LAST_BK = AW'(BANK_B_BASE + NUM_PAIRS - 1);

    logic [AW-1:0] last;
    logic [AW-1:0] stepped;

    always_comb begin
        last = banked ? LAST_BK : LAST_IL;
        unique case (step_kind(banked, hold))
            STEP_INC:    stepped = (cur >= last) ? '0 : cur + 1'b1;
            STEP_TOGGLE: stepped = {cur[AW-1:1], ~cur[0]};
            default:     stepped = cur;
        endcase
        if (load)
            nxt = load_addr;
        else if (adv)
            nxt = stepped;
        else
            nxt = cur;
    end

endmodule

// File: rtl/regptr_map.sv
module regptr_map
    import regptr_pkg::*;
#(
    parameter int unsigned AW          = ADDR_W_DEF,
    parameter int unsigned NUM_PAIRS   = PAIRS_DEF,
    parameter int unsigned BANK_B_BASE = BANK_B_DEF,
    parameter int unsigned CFG_PAIR    = CFG_PAIR_DEF,
    parameter int unsigned PW          = $clog2(NUM_PAIRS),
    parameter int unsigned IW          = PW + 1
) (
    input  logic [AW-1:0] addr,
    input  logic          banked,
    output logic [IW-1:0] index,
    output map_flags_t    flags
);
    localparam logic [AW-1:0] PAIRS_A  = AW'(NUM_PAIRS);
    localparam logic [AW-1:0] B_BASE_A = AW'(BANK_B_BASE);
    localparam logic [AW-1:0] B_END_A  = AW'(BANK_B_BASE + NUM_PAIRS);
    localparam logic [AW-1:0] IL_END_A = AW'(2 * NUM_PAIRS);
    localparam logic [PW-1:0] CFG_P    = PW'(CFG_PAIR);

    logic [PW-1:0] pair;
    logic          hit;
    logic          port_b;
    logic [AW-1:0] b_off;

    always_comb begin
        b_off  = addr - B_BASE_A;
        pair   = '0;
        hit    = 1'b0;
        port_b = 1'b0;
        if (banked) begin
            if (addr < PAIRS_A) begin
                hit  = 1'b1;
                pair = PW'(addr);
            end else if (addr >= B_BASE_A && addr < B_END_A) begin
                hit    = 1'b1;
                port_b = 1'b1;
                pair   = PW'(b_off);
            end
        end else if (addr < IL_END_A) begin
            hit    = 1'b1;
            port_b = addr[0];
            pair   = PW'(addr >> 1);
        end
        index        = hit ? {pair, port_b} : '0;
        flags.valid  = hit;
        flags.port_b = hit & port_b;
        flags.cfg    = hit && (pair == CFG_P);
    end

endmodule

// File: rtl/regptr_unit.sv
module regptr_unit
    import regptr_pkg::*;
#(
    parameter int unsigned AW          = ADDR_W_DEF,
    parameter int unsigned NUM_PAIRS   = PAIRS_DEF,
    parameter int unsigned BANK_B_BASE = BANK_B_DEF,
    parameter int unsigned CFG_PAIR    = CFG_PAIR_DEF,
    parameter int unsigned IW          = $clog2(NUM_PAIRS) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_load_addr,
    input  logic          ptr_adv,
    input  logic          map_banked,
    input  logic          hold_mode,
    output logic [AW-1:0] ptr_addr,
    output logic          reg_valid,
    output logic [IW-1:0] reg_index,
    output logic          reg_port_b,
    output logic          cfg_sel
);
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_d;
    map_flags_t    flags;

    regptr_step #(
        .AW(AW), .NUM_PAIRS(NUM_PAIRS), .BANK_B_BASE(BANK_B_BASE)
    ) u_step (
        .cur(ptr_q), .banked(map_banked), .hold(hold_mode),
        .load(ptr_load), .load_addr(ptr_load_addr), .adv(ptr_adv),
        .nxt(ptr_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end

    regptr_map #(
        .AW(AW), .NUM_PAIRS(NUM_PAIRS), .BANK_B_BASE(BANK_B_BASE),
        .CFG_PAIR(CFG_PAIR), .PW(IW - 1), .IW(IW)
    ) u_map (
        .addr(ptr_q), .banked(map_banked), .index(reg_index), .flags(flags)
    );

    assign ptr_addr   = ptr_q;
    assign reg_valid  = flags.valid;
    assign reg_port_b = flags.port_b;
    assign cfg_sel    = flags.cfg;

endmodule

// File: rtl/regptr_unit_chk.sv
module regptr_unit_chk #(
    parameter int unsigned AW          = 5,
    parameter int unsigned NUM_PAIRS   = 11,
    parameter int unsigned BANK_B_BASE = 16,
    parameter int unsigned IW          = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          ptr_load,
    input logic [AW-1:0] ptr_load_addr,
    input logic          ptr_adv,
    input logic          map_banked,
    input logic          hold_mode,
    input logic [AW-1:0] ptr_addr,
    input logic          reg_valid,
    input logic [IW-1:0] reg_index,
    input logic          reg_port_b,
    input logic          cfg_sel
);
    localparam logic [AW-1:0] LAST_IL = AW'(2 * NUM_PAIRS - 1);
    localparam logic [AW-1:0] LAST_BK = AW'(BANK_B_BASE + NUM_PAIRS - 1);

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        ptr_load |=> ptr_addr == $past(ptr_load_addr));

    p_invalid_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !reg_valid |-> (reg_index == '0 && !reg_port_b && !cfg_sel));

    p_cfg_valid_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_sel |-> reg_valid);

    p_seq_il_r6: assert property (@(posedge clk) disable iff (rst)
        (!ptr_load && ptr_adv && !hold_mode && !map_banked && ptr_addr < LAST_IL)
        |=> ptr_addr == AW'($past(ptr_addr) + AW'(1)));

    p_seq_bk_r7: assert property (@(posedge clk) disable iff (rst)
        (!ptr_load && ptr_adv && !hold_mode && map_banked && ptr_addr >= LAST_BK)
        |=> ptr_addr == '0);

    p_toggle_r8: assert property (@(posedge clk) disable iff (rst)
        (!ptr_load && ptr_adv && hold_mode && !map_banked)
        |=> ptr_addr == ($past(ptr_addr) ^ AW'(1)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ptr_load && ptr_adv && hold_mode && map_banked) |=> $stable(ptr_addr));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!ptr_load && !ptr_adv) |=> $stable(ptr_addr));

endmodule

bind regptr_unit regptr_unit_chk #(
    .AW(AW), .NUM_PAIRS(NUM_PAIRS), .BANK_B_BASE(BANK_B_BASE), .IW(IW)
) u_chk (
    .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_load_addr(ptr_load_addr),
    .ptr_adv(ptr_adv), .map_banked(map_banked), .hold_mode(hold_mode),
    .ptr_addr(ptr_addr), .reg_valid(reg_valid), .reg_index(reg_index),
    .reg_port_b(reg_port_b), .cfg_sel(cfg_sel)
);

// File: tb/tb_regptr_unit.sv
module tb_regptr_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ptr_load = 1'b0;
    logic [4:0] ptr_load_addr = '0;
    logic       ptr_adv = 1'b0;
    logic       map_banked = 1'b0;
    logic       hold_mode = 1'b0;
    logic [4:0] ptr_addr;
    logic       reg_valid;
    logic [4:0] reg_index;
    logic       reg_port_b;
    logic       cfg_sel;

    int n_checks = 0;
    int n_fails  = 0;

    always #4ns clk = ~clk;

    regptr_unit dut (
        .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_load_addr(ptr_load_addr),
        .ptr_adv(ptr_adv), .map_banked(map_banked), .hold_mode(hold_mode),
        .ptr_addr(ptr_addr), .reg_valid(reg_valid), .reg_index(reg_index),
        .reg_port_b(reg_port_b), .cfg_sel(cfg_sel)
    );

    typedef struct packed {
        logic       ld;
        logic [4:0] la;
        logic       adv;
        logic       bk;
        logic       hd;
        logic [4:0] eptr;
        logic       ev;
        logic [4:0] eidx;
        logic       eb;
        logic       ec;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 5'h14, 1'b0, 1'b0, 1'b0, 5'h14, 1'b1, 5'd20, 1'b0, 1'b0},
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 5'h15, 1'b1, 5'd21, 1'b1, 1'b0},
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 5'd0,  1'b0, 1'b0},
        '{1'b1, 5'h0A, 1'b0, 1'b0, 1'b0, 5'h0A, 1'b1, 5'd10, 1'b0, 1'b1},
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b1, 5'h0B, 1'b1, 5'd11, 1'b1, 1'b1},
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b1, 5'h0A, 1'b1, 5'd10, 1'b0, 1'b1},
        '{1'b1, 5'h13, 1'b0, 1'b0, 1'b1, 5'h13, 1'b1, 5'd19, 1'b1, 1'b0},
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b1, 5'h12, 1'b1, 5'd18, 1'b0, 1'b0},
        '{1'b1, 5'h1A, 1'b0, 1'b1, 1'b0, 5'h1A, 1'b1, 5'd21, 1'b1, 1'b0},
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 5'd0,  1'b0, 1'b0},
        '{1'b1, 5'h0A, 1'b0, 1'b1, 1'b0, 5'h0A, 1'b1, 5'd20, 1'b0, 1'b0},
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 5'h0B, 1'b0, 5'd0,  1'b0, 1'b0},
        '{1'b1, 5'h15, 1'b0, 1'b1, 1'b0, 5'h15, 1'b1, 5'd11, 1'b1, 1'b1},
        '{1'b1, 5'h05, 1'b0, 1'b1, 1'b0, 5'h05, 1'b1, 5'd10, 1'b0, 1'b1},
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b1, 5'h05, 1'b1, 5'd10, 1'b0, 1'b1},
        '{1'b1, 5'h10, 1'b1, 1'b1, 1'b0, 5'h10, 1'b1, 5'd1,  1'b1, 1'b0},
        '{1'b1, 5'h16, 1'b0, 1'b0, 1'b0, 5'h16, 1'b0, 5'd0,  1'b0, 1'b0},
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 5'd0,  1'b0, 1'b0},
        '{1'b1, 5'h11, 1'b0, 1'b0, 1'b0, 5'h11, 1'b1, 5'd17, 1'b1, 1'b0},
        '{1'b0, 5'h00, 1'b0, 1'b1, 1'b0, 5'h11, 1'b1, 5'd3,  1'b1, 1'b0},
        '{1'b1, 5'h1F, 1'b0, 1'b1, 1'b0, 5'h1F, 1'b0, 5'd0,  1'b0, 1'b0},
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 5'd0,  1'b0, 1'b0},
        '{1'b1, 5'h0F, 1'b0, 1'b1, 1'b0, 5'h0F, 1'b0, 5'd0,  1'b0, 1'b0},
        '{1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 5'h10, 1'b1, 5'd1,  1'b1, 1'b0}
    };

    localparam string TAG [0:NV-1] = '{
        "R2 R3", "R6", "R6", "R5", "R8", "R8", "R3", "R8",
        "R4", "R7", "R4", "R7 R4", "R5", "R5", "R9", "R2",
        "R3", "R6", "R3", "R10", "R4", "R7", "R4", "R7"
    };

    task automatic check(input string tag, input logic [4:0] eptr, input logic ev,
                         input logic [4:0] eidx, input logic eb, input logic ec);
        n_checks++;
        if (ptr_addr !== eptr || reg_valid !== ev || reg_index !== eidx ||
            reg_port_b !== eb || cfg_sel !== ec) begin
            n_fails++;
            $display("FAIL %s: got ptr=%h v=%b idx=%0d b=%b cfg=%b, expected ptr=%h v=%b idx=%0d b=%b cfg=%b",
                     tag, ptr_addr, reg_valid, reg_index, reg_port_b, cfg_sel,
                     eptr, ev, eidx, eb, ec);
        end
    endtask

    task automatic drive(input logic ld, input logic [4:0] la, input logic adv,
                         input logic bk, input logic hd);
        ptr_load      = ld;
        ptr_load_addr = la;
        ptr_adv       = adv;
        map_banked    = bk;
        hold_mode     = hd;
    endtask

    initial begin
        #(200000 * 8ns);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset", 5'h00, 1'b1, 5'd0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", 5'h00, 1'b1, 5'd0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].ld, VEC[i].la, VEC[i].adv, VEC[i].bk, VEC[i].hd);
            @(negedge clk);
            check(TAG[i], VEC[i].eptr, VEC[i].ev, VEC[i].eidx, VEC[i].eb, VEC[i].ec);
        end

        // R9: repeated byte-mode advances in the banked map hold the pointer
        drive(1'b1, 5'h03, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check("R9 load", 5'h03, 1'b1, 5'd6, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 5'h00, 1'b1, 1'b1, 1'b1);
            @(negedge clk);
            check("R9 hold", 5'h03, 1'b1, 5'd6, 1'b0, 1'b0);
        end

        // R10: idle cycles keep the pointer in byte mode
        drive(1'b0, 5'h00, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R10 idle", 5'h03, 1'b1, 5'd3, 1'b1, 1'b0);

        // R1: reset overrides a load and an advance
        drive(1'b1, 5'h13, 1'b1, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run", 5'h00, 1'b1, 5'd0, 1'b0, 1'b0);
        rst = 1'b0;
        drive(1'b0, 5'h00, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R1 stays", 5'h00, 1'b1, 5'd0, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule